// File: doc/BRIEF.md
# Byte/Word Switchable Static RAM

This block is a synthesizable static memory with a pin-style control interface. Two chip enables must both be active to select it: one is active low and the other active high. Write enable and output enable are both active low. A configuration input chooses how the memory is organised. It can be a set of 16-bit words, where two active-low lane controls gate the low and high bytes. It can also be twice as many 8-bit bytes, where an extra address input acts as the lowest address bit and picks one half of a word.

The bidirectional data bus is split into an input vector, an output vector and a per-bit output-enable vector. A bit whose enable is low models a high-impedance pin. Storage is one word-wide array built as two byte lanes, each with its own write strobe, so both organisations share the same cells. A byte written in byte mode is therefore visible in word mode as one half of a word, and the reverse also holds.

Writes commit at the rising clock edge. The `READ_LAT` parameter sets the read path. With 0, the outputs follow the controls and the address combinationally. With 1, the outputs are registered and show the result one clock later. The interface is a memory pin interface with no streaming handshake, so all control pins are plain levels.

Top module: `dualorg_sram`

## Requirements
- R1: The block is selected only while `cs_a_n`=0 and `cs_b`=1. Otherwise every `dq_oe` bit is 0 and no write takes place.
- R2: In word mode (`wide_mode`=1), the block counts as deselected while both `lane_lo_n` and `lane_hi_n` are 1: it drives nothing and writes nothing.
- R3: `wide_mode`=1 selects 16-bit word organisation and `wide_mode`=0 selects byte organisation. In byte mode, `byte_sel`=0 addresses bits 7:0 of the word at `addr`, and `byte_sel`=1 addresses bits 15:8 of that word.
- R4: In word mode, `byte_sel` has no effect on reads or writes.
- R5: While selected with `we_n`=0, the data on `dq_in` is written at the rising clock edge whatever `oe_n` is, and all `dq_oe` bits are 0.
- R6: While selected with `we_n`=1 and `oe_n`=0, read data is driven. With `oe_n`=1, all `dq_oe` bits are 0.
- R7: In word mode, `lane_lo_n`=0 enables bits 7:0 and `lane_hi_n`=0 enables bits 15:8, for both reads and writes. A lane that is not enabled is neither driven nor changed in storage.
- R8: In byte mode, only `dq_in[7:0]` and `dq_out[7:0]` carry data, with `dq_oe` = 16'h00FF on a read, and `lane_lo_n` and `lane_hi_n` are ignored.
- R9: With `READ_LAT`=0, outputs respond in the same cycle. With `READ_LAT`=1, `dq_out` and `dq_oe` show, after each rising edge, the values sampled just before that edge, and they are 0 during reset.
- R10: Every `dq_out` bit whose `dq_oe` bit is 0 reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and the registered read path act on its rising edge |
| rst_n | input | 1 | Active-low reset for the registered read path |
| cs_a_n | input | 1 | Chip enable, active low |
| cs_b | input | 1 | Chip enable, active high |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| wide_mode | input | 1 | 1 = 16-bit words, 0 = 8-bit bytes |
| lane_lo_n | input | 1 | Low-byte lane enable, active low, word mode only |
| lane_hi_n | input | 1 | High-byte lane enable, active low, word mode only |
| byte_sel | input | 1 | Lowest byte address bit in byte mode |
| addr | input | ADDR_W | Word address |
| dq_in | input | 16 | Data bus input side |
| dq_out | output | 16 | Data bus output side |
| dq_oe | output | 16 | Per-bit output enable of the data bus |

## Verification
The hardest case to reach from the ports is a half of a word that must survive a write aimed at the other half. This can be a lane write in word mode, a byte write in byte mode, or a word-mode write whose ignored `byte_sel` points at the wrong half. The stimulus table first fills a word through both lanes. It then overwrites one half at a time through both organisations, with upper-byte input data that must not land, and reads back the whole word in word mode after each step. A second instance with the registered read path sees the same inputs and is checked both before and after each edge, which shows the one-cycle delay.

// File: rtl/dualorg_sram_pkg.sv
package dualorg_sram_pkg;
  localparam int LANE_W = 8;
  localparam int LANES  = 2;
  localparam int DATA_W = LANE_W * LANES;

  typedef logic [LANES-1:0]  lane_mask_t;
  typedef logic [DATA_W-1:0] word_t;
  typedef logic [LANE_W-1:0] byte_t;
endpackage

// File: rtl/dualorg_sram_decode.sv
module dualorg_sram_decode
  import dualorg_sram_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_a_n,
  input  logic       cs_b,
  input  logic       oe_n,
  input  logic       we_n,
  input  logic       wide_mode,
  input  logic       lane_lo_n,
  input  logic       lane_hi_n,
  input  logic       byte_sel,
  output lane_mask_t wr_strb,
  output lane_mask_t rd_lanes,
  output logic       rd_upper
);
  logic       chip_on;
  logic       selected;
  lane_mask_t lane_req;

  always_comb begin
    chip_on = !cs_a_n && cs_b;
    if (wide_mode) lane_req = {!lane_hi_n, !lane_lo_n};
    else           lane_req = byte_sel ? 2'b10 : 2'b01;
    selected = chip_on && (wide_mode ? (|lane_req) : 1'b1);
  end

  always_comb begin
    wr_strb  = '0;
    rd_lanes = '0;
    if (selected && !we_n) wr_strb = lane_req;
    if (selected && we_n && !oe_n) rd_lanes = wide_mode ? lane_req : 2'b01;
    rd_upper = !wide_mode && byte_sel;
  end

  // R8
  byte_strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wide_mode |-> $onehot0(wr_strb));

  // R5
  no_read_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> rd_lanes == '0);
endmodule

// File: rtl/dualorg_sram_array.sv
module dualorg_sram_array
  import dualorg_sram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  lane_mask_t        wr_strb,
  input  word_t             wr_data,
  output word_t             rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    byte_t cells [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_strb[g]) cells[addr] <= wr_data[g*LANE_W +: LANE_W];
    end

    assign rd_data[g*LANE_W +: LANE_W] = cells[addr];

    // R7
    lane_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_strb[g]) |-> cells[$past(addr)] == $past(wr_data[g*LANE_W +: LANE_W]));
  end
endmodule

// File: rtl/dualorg_sram_rdpath.sv
module dualorg_sram_rdpath
  import dualorg_sram_pkg::*;
#(
  parameter int READ_LAT = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  word_t      word_rd,
  input  lane_mask_t rd_lanes,
  input  logic       rd_upper,
  output word_t      dq_out,
  output word_t      dq_oe
);
  word_t steered;
  word_t pin_en;

  always_comb begin
    steered = rd_upper ? {{LANE_W{1'b0}}, word_rd[DATA_W-1 -: LANE_W]} : word_rd;
    for (int k = 0; k < LANES; k++) pin_en[k*LANE_W +: LANE_W] = {LANE_W{rd_lanes[k]}};
  end

  if (READ_LAT == 0) begin : g_comb
    assign dq_out = steered & pin_en;
    assign dq_oe  = pin_en;
  end else begin : g_reg
    word_t out_q, oe_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_q <= '0;
        oe_q  <= '0;
      end else begin
        out_q <= steered & pin_en;
        oe_q  <= pin_en;
      end
    end
    assign dq_out = out_q;
    assign dq_oe  = oe_q;
  end
endmodule

// File: rtl/dualorg_sram.sv
module dualorg_sram
  import dualorg_sram_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int READ_LAT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_a_n,
  input  logic              cs_b,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              wide_mode,
  input  logic              lane_lo_n,
  input  logic              lane_hi_n,
  input  logic              byte_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       dq_in,
  output logic [15:0]       dq_out,
  output logic [15:0]       dq_oe
);
  lane_mask_t wr_strb;
  lane_mask_t rd_lanes;
  logic       rd_upper;
  word_t      wr_data;
  word_t      word_rd;

  dualorg_sram_decode u_decode (
    .clk(clk), .rst_n(rst_n), .cs_a_n(cs_a_n), .cs_b(cs_b), .oe_n(oe_n),
    .we_n(we_n), .wide_mode(wide_mode), .lane_lo_n(lane_lo_n),
    .lane_hi_n(lane_hi_n), .byte_sel(byte_sel), .wr_strb(wr_strb),
    .rd_lanes(rd_lanes), .rd_upper(rd_upper)
  );

  // byte mode replicates the low input byte; the strobe picks the half
  assign wr_data = wide_mode ? dq_in : {LANES{dq_in[LANE_W-1:0]}};

  dualorg_sram_array #(.ADDR_W(ADDR_W)) u_array (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_strb(wr_strb),
    .wr_data(wr_data), .rd_data(word_rd)
  );

  dualorg_sram_rdpath #(.READ_LAT(READ_LAT)) u_rdpath (
    .clk(clk), .rst_n(rst_n), .word_rd(word_rd), .rd_lanes(rd_lanes),
    .rd_upper(rd_upper), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  if (READ_LAT == 0) begin : g_chk_now
    // R1
    deselect_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_a_n || !cs_b) |-> dq_oe == '0);
    // R8
    byte_upper_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wide_mode |-> dq_oe[15:8] == '0);
    // R6
    oe_off_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> dq_oe == '0);
  end else begin : g_chk_late
    // R1
    deselect_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_a_n || !cs_b) |=> dq_oe == '0);
    // R8
    byte_upper_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wide_mode |=> dq_oe[15:8] == '0);
    // R6
    oe_off_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |=> dq_oe == '0);
  end
endmodule

// File: tb/dualorg_sram_test.sv
module dualorg_sram_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int NVEC = 21;

  typedef struct packed {
    logic [3:0]    req;
    logic          wide, csa_n, csb, oen, wen, lon, hin, bsel;
    logic [AW-1:0] ad;
    logic [15:0]   din, eout, eoe;
  } vec_t;

  // fields: req, wide, cs_a_n, cs_b, oe_n, we_n, lane_lo_n, lane_hi_n, byte_sel, addr, din, exp_out, exp_oe
  localparam vec_t VEC [NVEC] = '{
    '{4'd5,  1,0,1,1,0,0,0,0, 6'd3,  16'hA1B2, 16'h0000, 16'h0000}, // R5 word write
    '{4'd6,  1,0,1,0,1,0,0,0, 6'd3,  16'h0000, 16'hA1B2, 16'hFFFF}, // R6 read
    '{4'd10, 1,0,1,0,1,0,1,0, 6'd3,  16'h0000, 16'h00B2, 16'h00FF}, // R10 / R7 low lane
    '{4'd7,  1,0,1,0,1,1,0,0, 6'd3,  16'h0000, 16'hA100, 16'hFF00}, // R7 high lane
    '{4'd7,  1,0,1,1,0,1,0,0, 6'd3,  16'h5CEE, 16'h0000, 16'h0000}, // R7 high-lane write
    '{4'd7,  1,0,1,0,1,0,0,0, 6'd3,  16'h0000, 16'h5CB2, 16'hFFFF}, // R7 low kept
    '{4'd5,  0,0,1,0,0,1,1,0, 6'd3,  16'hEE77, 16'h0000, 16'h0000}, // R5 byte write, oe_n low
    '{4'd3,  0,0,1,0,1,1,1,1, 6'd3,  16'h0000, 16'h005C, 16'h00FF}, // R3 upper half
    '{4'd8,  0,0,1,0,1,0,0,0, 6'd3,  16'h0000, 16'h0077, 16'h00FF}, // R8 lanes ignored
    '{4'd4,  1,0,1,0,1,0,0,1, 6'd3,  16'h0000, 16'h5C77, 16'hFFFF}, // R4 byte_sel ignored
    '{4'd1,  1,1,1,1,0,0,0,0, 6'd3,  16'hFFFF, 16'h0000, 16'h0000}, // R1 cs_a_n off
    '{4'd1,  1,0,0,1,0,0,0,0, 6'd3,  16'hFFFF, 16'h0000, 16'h0000}, // R1 cs_b off
    '{4'd2,  1,0,1,1,0,1,1,0, 6'd3,  16'h1111, 16'h0000, 16'h0000}, // R2 both lanes off write
    '{4'd2,  1,0,1,0,1,1,1,0, 6'd3,  16'h0000, 16'h0000, 16'h0000}, // R2 both lanes off read
    '{4'd1,  1,0,1,0,1,0,0,0, 6'd3,  16'h0000, 16'h5C77, 16'hFFFF}, // R1 R2 no write landed
    '{4'd6,  1,0,1,1,1,0,0,0, 6'd3,  16'h0000, 16'h0000, 16'h0000}, // R6 oe_n high
    '{4'd3,  1,0,1,1,0,0,0,0, 6'd10, 16'h1234, 16'h0000, 16'h0000}, // R3 prefill
    '{4'd3,  0,0,1,1,0,1,1,1, 6'd10, 16'h00AB, 16'h0000, 16'h0000}, // R3 byte write upper
    '{4'd3,  1,0,1,0,1,0,0,0, 6'd10, 16'h0000, 16'hAB34, 16'hFFFF}, // R3 seen in word mode
    '{4'd4,  1,0,1,1,0,0,1,1, 6'd10, 16'h9999, 16'h0000, 16'h0000}, // R4 low lane, byte_sel=1
    '{4'd4,  1,0,1,0,1,0,0,1, 6'd10, 16'h0000, 16'hAB99, 16'hFFFF}  // R4 readback
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_a_n = 1'b1, cs_b = 1'b0, oe_n = 1'b1, we_n = 1'b1;
  logic wide_mode = 1'b1, lane_lo_n = 1'b1, lane_hi_n = 1'b1, byte_sel = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [15:0] dq_in = '0;
  logic [15:0] dq_out, dq_oe, q_out, q_oe;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dualorg_sram #(.ADDR_W(AW), .READ_LAT(0)) uut (
    .clk(clk), .rst_n(rst_n), .cs_a_n(cs_a_n), .cs_b(cs_b), .oe_n(oe_n),
    .we_n(we_n), .wide_mode(wide_mode), .lane_lo_n(lane_lo_n),
    .lane_hi_n(lane_hi_n), .byte_sel(byte_sel), .addr(addr), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  dualorg_sram #(.ADDR_W(AW), .READ_LAT(1)) uut_q (
    .clk(clk), .rst_n(rst_n), .cs_a_n(cs_a_n), .cs_b(cs_b), .oe_n(oe_n),
    .we_n(we_n), .wide_mode(wide_mode), .lane_lo_n(lane_lo_n),
    .lane_hi_n(lane_hi_n), .byte_sel(byte_sel), .addr(addr), .dq_in(dq_in),
    .dq_out(q_out), .dq_oe(q_oe)
  );

  task automatic check(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [15:0] prev_out, prev_oe;
    repeat (3) @(posedge clk);
    #1;
    // R9 registered path held at zero in reset
    check("R9", "reset q_oe", q_oe, 16'h0000);
    check("R9", "reset q_out", q_out, 16'h0000);
    // R1 deselected at reset
    check("R1", "reset dq_oe", dq_oe, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    prev_out = '0;
    prev_oe  = '0;
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      {wide_mode, cs_a_n, cs_b, oe_n, we_n, lane_lo_n, lane_hi_n, byte_sel} =
        {VEC[i].wide, VEC[i].csa_n, VEC[i].csb, VEC[i].oen, VEC[i].wen,
         VEC[i].lon, VEC[i].hin, VEC[i].bsel};
      addr  = VEC[i].ad;
      dq_in = VEC[i].din;
      #1;
      check($sformatf("R%0d", VEC[i].req), $sformatf("vec%0d dq_out", i), dq_out, VEC[i].eout);
      check($sformatf("R%0d", VEC[i].req), $sformatf("vec%0d dq_oe", i), dq_oe, VEC[i].eoe);
      // R9 registered copy still shows the previous step before the edge
      check("R9", $sformatf("vec%0d q_out before edge", i), q_out, prev_out);
      @(posedge clk);
      #1;
      check("R9", $sformatf("vec%0d q_out after edge", i), q_out, VEC[i].eout);
      check("R9", $sformatf("vec%0d q_oe after edge", i), q_oe, VEC[i].eoe);
      prev_out = VEC[i].eout;
      prev_oe  = VEC[i].eoe;
    end
    check("R9", "last q_oe held", q_oe, prev_oe);
    // R8 directed: byte-mode write with high-lane pins low must not touch upper half
    @(negedge clk);
    {wide_mode, cs_a_n, cs_b, oe_n, we_n, lane_lo_n, lane_hi_n, byte_sel} = 8'b0_0_1_1_0_0_0_0;
    addr = 6'd10; dq_in = 16'h4466;
    @(negedge clk);
    {wide_mode, oe_n, we_n} = 3'b1_0_1;
    #1;
    check("R8", "byte write low half only", dq_out, 16'hAB66);
    // R2 directed: deselected by lanes even with oe_n low
    lane_lo_n = 1'b1; lane_hi_n = 1'b1;
    #1;
    check("R2", "both lanes off no drive", dq_oe, 16'h0000);
    done = 1'b1;
    finish_run();
  end
endmodule